// File: doc/BRIEF.md
# One-Hot Fault Injection Sequencer

This block steers fault injection inside an emulated netlist. Each fault site carries two versions of its logic value: the fault-free one and the one with the fault applied. A per-site selector passes one of them to the site output. The selector is controlled by one bit of an enable vector. The enable vector is a circular register that holds exactly one set bit, so only one site behaves as faulty at any moment while all the other sites pass their fault-free values.

An advance strobe moves the single set bit to the next site. After the last site it wraps back to site 0, and the block raises a one-cycle wrap pulse so the surrounding test flow knows that every fault has been visited once. A synchronous load returns the activation to site 0 from any state. The binary number of the active site is also provided, so results collected downstream can be tagged with the fault they belong to. Changing the active fault needs no reconfiguration, only one strobe.

Top module: `fault_rotor`

## Requirements
- R1: While reset (active-low, asynchronous) is held and in the first cycle after it is released, `fault_en` is 1 at bit 0 only, `active_idx` is 0 and `wrap` is 0.
- R2: For every site i, slice i of `site_out` (bits i*SITE_W+SITE_W-1 down to i*SITE_W) equals slice i of `bad_vals` when `fault_en[i]` is 1, and slice i of `good_vals` otherwise. The selection is combinational on the data inputs.
- R3: `fault_en` has exactly one bit set in every cycle.
- R4: A clock edge with `advance`=1 and `load`=0 moves the set bit from position i to position i+1, visible in the following cycle.
- R5: When `advance`=1 and `load`=0 while bit NUM_SITES-1 is set, the set bit moves to position 0. `wrap` is 1 for exactly the following cycle and 0 in every other cycle.
- R6: A clock edge with `load`=1 puts the set bit at position 0 whatever the current state, even when `advance` is also 1. That edge produces no wrap pulse.
- R7: A clock edge with both `advance` and `load` at 0 leaves `fault_en` and `active_idx` unchanged.
- R8: `active_idx` is the binary position of the set bit in `fault_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Synchronous return of activation to site 0 |
| advance | input | 1 | Step activation to the next site |
| good_vals | input | NUM_SITES*SITE_W | Fault-free value of each site, site 0 in the low slice |
| bad_vals | input | NUM_SITES*SITE_W | Faulty value of each site, site 0 in the low slice |
| site_out | output | NUM_SITES*SITE_W | Selected value of each site |
| fault_en | output | NUM_SITES | One-hot activation vector |
| active_idx | output | IDX_W | Binary number of the active site |
| wrap | output | 1 | One-cycle pulse after activation returns from the last site to site 0 |

## Verification
A corrupted activation register shows at the ports in the same cycle. Either two sites emit faulty data at once, or no site does, and `active_idx` then stops matching `fault_en`. A rotation error that skips or repeats a site shows one cycle after the strobe as a wrong index. A mis-timed wrap shows as a pulse that appears or is missing in that same cycle. The bench follows the position with a counter model and checks every output field every cycle, so each such error is reported within one clock of when it appears.

// File: rtl/fr_pkg.sv
package fr_pkg;

  // Width of a binary index for n sites (at least one bit).
  function automatic int unsigned fr_idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Position that feeds position i in a ring of n sites.
  function automatic int unsigned fr_pred(input int unsigned i, input int unsigned n);
    return (i == 0) ? n - 1 : i - 1;
  endfunction

  // Position after i in a ring of n sites.
  function automatic int unsigned fr_succ(input int unsigned i, input int unsigned n);
    return (i + 1 == n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/fr_ring.sv
module fr_ring
  import fr_pkg::*;
#(
  parameter int unsigned NUM_SITES = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  output logic [NUM_SITES-1:0] en_o,
  output logic                 wrap_o
);

  localparam logic [NUM_SITES-1:0] HOME = NUM_SITES'(1);

  logic [NUM_SITES-1:0] ring_q;
  logic [NUM_SITES-1:0] rot_n;
  logic                 wrap_q;

  // Named events for the assertions.
  logic step_fire;
  logic at_last;
  assign step_fire = step_i && !load_i;
  assign at_last   = ring_q[NUM_SITES-1];

  // Each position takes its value from its predecessor.
  for (genvar i = 0; i < NUM_SITES; i++) begin : g_rot
    assign rot_n[i] = ring_q[fr_pred(i, NUM_SITES)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= HOME;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= step_fire && at_last;
      if (load_i)
        ring_q <= HOME;
      else if (step_i)
        ring_q <= rot_n;
    end
  end

  assign en_o   = ring_q;
  assign wrap_o = wrap_q;

  // R3
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == 1);

  // R6
  load_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ring_q == HOME) && !wrap_q);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(ring_q));

  // R4
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !at_last) |=> ring_q == ($past(ring_q) << 1));

  // R5
  wrap_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && at_last) |=> ring_q[0] && wrap_q);

  // R5
  wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_fire && at_last) |=> !wrap_q);

endmodule

// File: rtl/fr_locator.sv
module fr_locator #(
  parameter int unsigned NUM_SITES = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_SITES-1:0] en_i,
  output logic [IDX_W-1:0]     idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SITES; i++) begin
      if (en_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/fr_site_mux.sv
module fr_site_mux #(
  parameter int unsigned SITE_W = 4
) (
  input  logic [SITE_W-1:0] good_i,
  input  logic [SITE_W-1:0] bad_i,
  input  logic              sel_i,
  output logic [SITE_W-1:0] out_o
);

  assign out_o = sel_i ? bad_i : good_i;

endmodule

// File: rtl/fault_rotor.sv
module fault_rotor
  import fr_pkg::*;
#(
  parameter int unsigned NUM_SITES = 5,
  parameter int unsigned SITE_W    = 4,
  parameter int unsigned IDX_W     = fr_idx_width(NUM_SITES),
  localparam int unsigned BUS_W    = NUM_SITES * SITE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 advance,
  input  logic [BUS_W-1:0]     good_vals,
  input  logic [BUS_W-1:0]     bad_vals,
  output logic [BUS_W-1:0]     site_out,
  output logic [NUM_SITES-1:0] fault_en,
  output logic [IDX_W-1:0]     active_idx,
  output logic                 wrap
);

  logic [NUM_SITES-1:0] en_w;
  logic [IDX_W-1:0]     idx_w;
  logic                 wrap_w;

  fr_ring #(.NUM_SITES(NUM_SITES)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (advance),
    .en_o   (en_w),
    .wrap_o (wrap_w)
  );

  fr_locator #(.NUM_SITES(NUM_SITES), .IDX_W(IDX_W)) u_loc (
    .en_i  (en_w),
    .idx_o (idx_w)
  );

  for (genvar s = 0; s < NUM_SITES; s++) begin : g_site
    fr_site_mux #(.SITE_W(SITE_W)) u_mux (
      .good_i (good_vals[s*SITE_W +: SITE_W]),
      .bad_i  (bad_vals[s*SITE_W +: SITE_W]),
      .sel_i  (en_w[s]),
      .out_o  (site_out[s*SITE_W +: SITE_W])
    );
  end

  assign fault_en   = en_w;
  assign active_idx = idx_w;
  assign wrap       = wrap_w;

  // R8
  idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_en == (NUM_SITES'(1) << active_idx));

  // R5
  wrap_at_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> active_idx == '0);

endmodule

// File: tb/sim_fault_rotor.sv
`timescale 1ns/1ps
module sim_fault_rotor;

  localparam int N  = 5;
  localparam int W  = 4;
  localparam int IW = 3;
  localparam int BW = N * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          advance = 1'b0;
  logic [BW-1:0] good_vals = '0;
  logic [BW-1:0] bad_vals = '0;
  logic [BW-1:0] site_out;
  logic [N-1:0]  fault_en;
  logic [IW-1:0] active_idx;
  logic          wrap;

  always #10 clk = ~clk;  // 50 MHz

  fault_rotor #(.NUM_SITES(N), .SITE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .good_vals(good_vals), .bad_vals(bad_vals), .site_out(site_out),
    .fault_en(fault_en), .active_idx(active_idx), .wrap(wrap)
  );

  typedef struct {
    int            pos;
    logic          wrp;
    logic [BW-1:0] g;
    logic [BW-1:0] b;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   m_pos = 0;
  bit   done = 0;

  function automatic logic [BW-1:0] pick(input int pos, input logic [BW-1:0] g,
                                         input logic [BW-1:0] b);
    logic [BW-1:0] r;
    r = g;
    r[pos*W +: W] = b[pos*W +: W];
    return r;
  endfunction

  task automatic check_all(input exp_t e);
    logic [N-1:0]  e_en;
    logic [BW-1:0] e_out;
    e_en  = N'(1) << e.pos;
    e_out = pick(e.pos, e.g, e.b);
    n_cmp++;
    if (fault_en !== e_en) begin
      n_bad++;
      $display("FAIL %s/R3 fault_en got %b exp %b", e.tag, fault_en, e_en);
    end
    n_cmp++;
    if (active_idx !== IW'(e.pos)) begin
      n_bad++;
      $display("FAIL %s/R8 active_idx got %0d exp %0d", e.tag, active_idx, e.pos);
    end
    n_cmp++;
    if (wrap !== e.wrp) begin
      n_bad++;
      $display("FAIL %s/R5 wrap got %b exp %b", e.tag, wrap, e.wrp);
    end
    n_cmp++;
    if (site_out !== e_out) begin
      n_bad++;
      $display("FAIL %s/R2 site_out got %h exp %h", e.tag, site_out, e_out);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic adv, input logic ld, input logic [BW-1:0] g,
                      input logic [BW-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    advance   = adv;
    load      = ld;
    good_vals = g;
    bad_vals  = b;
    e.wrp = 1'b0;
    if (ld) m_pos = 0;
    else if (adv) begin
      e.wrp = (m_pos == N - 1);
      m_pos = (m_pos + 1) % N;
    end
    e.pos = m_pos;
    e.g   = g;
    e.b   = b;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares mid-cycle, after the edge that produced the item.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) check_all(q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    exp_t r;
    logic [BW-1:0] g;
    logic [BW-1:0] b;
    good_vals = 20'h12345;
    bad_vals  = 20'hEDCBA;
    repeat (3) @(negedge clk);
    // R1: state during reset
    r.pos = 0; r.wrp = 1'b0; r.g = good_vals; r.b = bad_vals; r.tag = "R1";
    check_all(r);
    rst_n = 1'b1;
    // R1: first cycle after release, R7 idle holds
    step(1'b0, 1'b0, 20'h12345, 20'hEDCBA, "R1");
    step(1'b0, 1'b0, 20'hFFFFF, 20'h00000, "R7");
    // R4/R5: twelve consecutive strobes, two wraps, varied data
    for (int k = 0; k < 12; k++) begin
      g = BW'(32'h9A3C5 * (k + 1));
      b = ~g ^ BW'(k * 32'h111);
      step(1'b1, 1'b0, g, b, (k % N == N - 1) ? "R5" : "R4");
    end
    // R7: idle in the middle of the ring, data changes only
    step(1'b0, 1'b0, 20'hAAAAA, 20'h55555, "R7");
    step(1'b0, 1'b0, 20'h0F0F0, 20'hF0F0F, "R7");
    step(1'b1, 1'b0, 20'h0F0F0, 20'hF0F0F, "R4");
    // R6: load from a middle site
    step(1'b0, 1'b1, 20'h13579, 20'h2468A, "R6");
    // walk to the last site, then load together with advance: no wrap
    for (int k = 0; k < N - 1; k++) step(1'b1, 1'b0, 20'h3C3C3, 20'hC3C3C, "R4");
    step(1'b1, 1'b1, 20'h3C3C3, 20'hC3C3C, "R6");
    step(1'b0, 1'b0, 20'h3C3C3, 20'hC3C3C, "R6");
    // R6: load while already at site 0
    step(1'b0, 1'b1, 20'h00000, 20'hFFFFF, "R6");
    // alternating strobes across a wrap
    for (int k = 0; k < 2 * N; k++) step(k[0], 1'b0, BW'(k * 32'h4321), BW'(~(k * 32'h1234)), "R5");
    step(1'b0, 1'b0, 20'h00000, 20'h00000, "R7");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule